// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into asynchronous serial frames on a single output line. Each frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a high stop period of 1, 1.5 or 2 bit times. The bit time is derived from an external transmit clock. That clock is brought into the system clock domain, and each of its falling edges becomes a one-cycle tick. A bit lasts 1, 16 or 64 ticks, chosen at run time.

A holding register sits in front of the shift register, so the next character can be written while the current one is still shifting out. Two flags report the buffer state: a ready flag shows when the holding register can take a new character, and an empty flag shows when no character is left anywhere in the block. Enable, clear-to-send and break inputs come from a neighbouring control block. Clear-to-send or enable can stop the loading of new characters, but a character that is already shifting always finishes. The break input forces the line low at once.

The frame settings (length, parity, stop length and rate) are captured when a character moves into the shifter. Settings changed during a frame therefore take effect with the next frame.

Top module: `ser_tx_core`

## Requirements
- R1: After reset, `txd` is 1, `txempty` is 1 and `txrdy` is 0 while `tx_en` is 0.
- R2: Each frame is a 0 start bit, then N data bits least significant bit first, where N = `cfg_len` + 5 (code 0 gives 5 bits, code 3 gives 8 bits), then the parity bit if enabled, then 1s for the stop period. Data bits above N are not sent.
- R3: When `cfg_par_en` is 1, the parity bit is the XOR of only the N active data bits, inverted when `cfg_par_odd` is 1.
- R4: One bit lasts F ticks of the transmit clock falling edge. F is 1 for `cfg_rate` 0, 16 for `cfg_rate` 1, and 64 for `cfg_rate` 2 or 3.
- R5: `cfg_stop` selects the stop period: code 0 gives F ticks, code 2 or 3 gives 2F ticks, and code 1 gives 1.5F ticks when F > 1 and 2 ticks when F = 1.
- R6: A character written while another is shifting starts on the tick that ends the previous stop period, with no idle gap. `txrdy` is 1 only when the holding register is empty.
- R7: `txempty` is 1 only when both the holding register and the shifter are empty. It falls within 2 clocks of a write.
- R8: When `tx_en` is 0 or `cts_n` is 1, no new character is loaded. A character already shifting is sent in full, and `txd` then stays 1. A character written while disabled is kept and sent after the transmitter is enabled again.
- R9: While `brk` is 1, `txd` is 0 one clock later.
- R10: `txrdy` is 0 whenever, in the previous clock, `tx_en` was 0 or `cts_n` was 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| txclk | input | 1 | External transmit clock; each falling edge is one tick |
| cfg_len | input | 2 | Character length code (N = code + 5) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | Odd parity select |
| cfg_stop | input | 2 | Stop length code |
| cfg_rate | input | 2 | Ticks-per-bit code |
| tx_en | input | 1 | Transmit enable from the control block |
| cts_n | input | 1 | Clear-to-send, active low |
| brk | input | 1 | Force line low |
| wr_valid | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line |
| txrdy | output | 1 | Holding register free and transmitter enabled |
| txempty | output | 1 | No character held or shifting |

## Verification
A scoreboard records the frame expected for every character written. A monitor rebuilds each frame from the serial line by sampling the middle of each bit.

The stimulus covers every character length, both parity senses, and characters whose unused upper bits are set. This separates correct masking of the parity and data bits from a parity computed over all eight bits.

Back-to-back pairs are sent at each rate and each stop code, and the time between start edges is measured. This separates the rate factors from one another, the 1.5-bit stop from the 1-bit and 2-bit stops, and shows the special case of the 1.5-bit stop at rate factor 1.

A clear-to-send drop in the middle of a frame shows that the character already shifting finishes and the held character waits. A break pulse shows the forced low level.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_DATA  = 2'd1,
    PH_PAR   = 2'd2,
    PH_STOP  = 2'd3
  } tx_phase_e;

  localparam int RATE_X1  = 0;
  localparam int RATE_MID = 1;
  localparam int STOP_ONE = 0;
  localparam int STOP_ONE_HALF = 1;

endpackage

// File: rtl/ser_tx_clkedge.sv
module ser_tx_clkedge (
  input  logic clk,
  input  logic rst,
  input  logic txclk,
  output logic tick
);
  logic sync1, sync2, prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
      prev  <= 1'b1;
    end else begin
      sync1 <= txclk;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign tick = prev & ~sync2;

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R4

endmodule

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else if (wr_valid) begin
      full <= 1'b1;
      data <= wr_data;
    end else if (load) begin
      full <= 1'b0;
    end
  end

  AST_LOAD_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    load |-> full); // R6

endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter
  import ser_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_LEN  = 5,
  parameter int FACT_MID = 16,
  parameter int FACT_HI  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              go_ok,
  input  logic [DATA_W-1:0] hold_data,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic [1:0]        cfg_stop,
  input  logic [1:0]        cfg_rate,
  output logic              load,
  output logic              busy,
  output logic              line
);
  localparam int CNT_W = $clog2(2 * FACT_HI + 1);
  localparam int LEN_W = $clog2(DATA_W + 1);

  tx_phase_e         ph;
  logic [CNT_W-1:0]  sub;
  logic [LEN_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              par_bit;
  logic [LEN_W-1:0]  len_q;
  logic              par_en_q;
  logic [1:0]        stop_q;
  logic [1:0]        rate_q;

  logic [CNT_W-1:0]  fact;
  logic [CNT_W-1:0]  stop_len;
  logic [CNT_W-1:0]  limit;
  logic              bit_end;
  logic              last_tick;
  logic [LEN_W-1:0]  len_new;
  logic [DATA_W-1:0] mask;

  assign len_new = LEN_W'(cfg_len) + LEN_W'(MIN_LEN);

  always_comb begin
    for (int i = 0; i < DATA_W; i++) mask[i] = (i < int'(len_new));
  end

  always_comb begin
    case (rate_q)
      2'd0:    fact = CNT_W'(1);
      2'd1:    fact = CNT_W'(FACT_MID);
      default: fact = CNT_W'(FACT_HI);
    endcase
    case (stop_q)
      2'd0:    stop_len = fact;
      2'd1:    stop_len = (rate_q == 2'(RATE_X1)) ? CNT_W'(2) : fact + (fact >> 1);
      default: stop_len = fact << 1;
    endcase
    limit = (ph == PH_STOP) ? stop_len : fact;
  end

  assign bit_end   = busy & tick & (sub == limit - CNT_W'(1));
  assign last_tick = bit_end & (ph == PH_STOP);
  assign load      = tick & go_ok & (~busy | last_tick);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      line     <= 1'b1;
      ph       <= PH_START;
      sub      <= '0;
      idx      <= '0;
      shreg    <= '0;
      par_bit  <= 1'b0;
      len_q    <= LEN_W'(DATA_W);
      par_en_q <= 1'b0;
      stop_q   <= 2'd0;
      rate_q   <= 2'd0;
    end else if (load) begin
      busy     <= 1'b1;
      line     <= 1'b0;
      ph       <= PH_START;
      sub      <= '0;
      idx      <= '0;
      shreg    <= hold_data;
      par_bit  <= (^(hold_data & mask)) ^ cfg_par_odd;
      len_q    <= len_new;
      par_en_q <= cfg_par_en;
      stop_q   <= cfg_stop;
      rate_q   <= cfg_rate;
    end else if (busy && tick) begin
      if (bit_end) begin
        sub <= '0;
        case (ph)
          PH_START: begin
            line  <= shreg[0];
            shreg <= shreg >> 1;
            idx   <= LEN_W'(1);
            ph    <= PH_DATA;
          end
          PH_DATA: begin
            if (idx == len_q) begin
              if (par_en_q) begin
                ph   <= PH_PAR;
                line <= par_bit;
              end else begin
                ph   <= PH_STOP;
                line <= 1'b1;
              end
            end else begin
              line  <= shreg[0];
              shreg <= shreg >> 1;
              idx   <= idx + LEN_W'(1);
            end
          end
          PH_PAR: begin
            ph   <= PH_STOP;
            line <= 1'b1;
          end
          default: begin
            busy <= 1'b0;
            line <= 1'b1;
          end
        endcase
      end else begin
        sub <= sub + CNT_W'(1);
      end
    end
  end

  AST_SUB_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (sub < limit)); // R4

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (idx <= len_q)); // R2

endmodule

// File: rtl/ser_tx_core.sv
module ser_tx_core #(
  parameter int DATA_W   = 8,
  parameter int MIN_LEN  = 5,
  parameter int FACT_MID = 16,
  parameter int FACT_HI  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txclk,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic [1:0]        cfg_stop,
  input  logic [1:0]        cfg_rate,
  input  logic              tx_en,
  input  logic              cts_n,
  input  logic              brk,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              txrdy,
  output logic              txempty
);
  logic              tick;
  logic              load;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              busy;
  logic              line;
  logic              enabled;

  assign enabled = tx_en & ~cts_n;

  ser_tx_clkedge u_edge (
    .clk   (clk),
    .rst   (rst),
    .txclk (txclk),
    .tick  (tick)
  );

  ser_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .load     (load),
    .full     (hold_full),
    .data     (hold_data)
  );

  ser_tx_shifter #(
    .DATA_W   (DATA_W),
    .MIN_LEN  (MIN_LEN),
    .FACT_MID (FACT_MID),
    .FACT_HI  (FACT_HI)
  ) u_shift (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .go_ok       (hold_full & enabled),
    .hold_data   (hold_data),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .cfg_stop    (cfg_stop),
    .cfg_rate    (cfg_rate),
    .load        (load),
    .busy        (busy),
    .line        (line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      txd     <= 1'b1;
      txrdy   <= 1'b0;
      txempty <= 1'b1;
    end else begin
      txd     <= brk ? 1'b0 : line;
      txrdy   <= ~hold_full & enabled;
      txempty <= ~hold_full & ~busy;
    end
  end

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
    $past(brk) |-> !txd); // R9

  AST_RDY_GATED: assert property (@(posedge clk) disable iff (rst)
    txrdy |-> $past(tx_en && !cts_n)); // R10

  AST_EMPTY_MARK: assert property (@(posedge clk) disable iff (rst)
    (txempty && !$past(brk)) |-> txd); // R7

endmodule

// File: tb/ser_tx_core_test.sv
module ser_tx_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int TXP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txclk = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic [1:0] cfg_stop = 2'd0, cfg_rate = 2'd1;
  logic tx_en = 1'b0, cts_n = 1'b0, brk = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic txd, txrdy, txempty;

  int checks = 0, errors = 0, cyc = 0;
  int bitclks = 16 * TXP;
  int cur_len = 8;
  bit cur_pe = 0, cur_odd = 0;
  bit mon_on = 1, mon_busy = 0, prev = 1;
  string cur_tag = "R2";
  logic [15:0] exp_q[$];
  int expn_q[$];
  int starts[$];

  ser_tx_core uut (
    .clk(clk), .rst(rst), .txclk(txclk), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop), .cfg_rate(cfg_rate), .tx_en(tx_en),
    .cts_n(cts_n), .brk(brk), .wr_valid(wr_valid), .wr_data(wr_data),
    .txd(txd), .txrdy(txrdy), .txempty(txempty)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;
  initial forever #(TXP*CLK_PERIOD/2) txclk = ~txclk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int len, input bit pe, input bit odd, input int stp, input int rate);
    cfg_len = 2'(len - 5); cfg_par_en = pe; cfg_par_odd = odd;
    cfg_stop = 2'(stp); cfg_rate = 2'(rate);
    cur_len = len; cur_pe = pe; cur_odd = odd;
    bitclks = (rate == 0 ? 1 : (rate == 1 ? 16 : 64)) * TXP;
  endtask

  task automatic push_exp(input logic [7:0] d);
    logic [15:0] v = '0;
    int n = 1;
    bit p = cur_odd;
    for (int i = 0; i < cur_len; i++) begin
      v[n] = d[i]; p = p ^ d[i]; n++;
    end
    if (cur_pe) begin v[n] = p; n++; end
    v[n] = 1'b1; n++;
    exp_q.push_back(v); expn_q.push_back(n);
  endtask

  task automatic write_char(input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d);
    while (!txrdy) @(negedge clk);
    push_exp(d);
    write_char(d);
  endtask

  task automatic drain();
    while (!(exp_q.size() == 0 && !mon_busy && txempty)) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor: rebuilds frames from txd, compares with queue
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && prev && !txd) begin
        logic [15:0] v, obs;
        int n;
        bit ok;
        mon_busy = 1;
        starts.push_back(cyc);
        repeat (bitclks/2) @(negedge clk);
        obs = '0; obs[0] = txd;
        if (exp_q.size() == 0) begin
          chk(0, cur_tag, 1, 0);
        end else begin
          v = exp_q.pop_front(); n = expn_q.pop_front();
          for (int i = 1; i < n; i++) begin
            repeat (bitclks) @(negedge clk);
            obs[i] = txd;
          end
          ok = 1;
          for (int i = 0; i < n; i++) if (obs[i] !== v[i]) ok = 0;
          chk(ok, cur_tag, int'(obs), int'(v));
        end
        mon_busy = 0;
      end
      prev = txd;
    end
  end

  task automatic gap_check(input string tag, input int ticks);
    int g = 0;
    if (starts.size() >= 2) g = starts[starts.size()-1] - starts[starts.size()-2];
    chk(g == ticks * TXP, tag, g, ticks * TXP);
  endtask

  task automatic pair(input logic [7:0] a, input logic [7:0] b, input string tag, input int ticks);
    starts.delete();
    send(a); send(b); drain();
    gap_check(tag, ticks);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R1", txd, 1);
    chk(txempty == 1'b1, "R1", txempty, 1);
    chk(txrdy == 1'b0, "R1", txrdy, 0);
    // R10: disabled by tx_en
    repeat (4) @(negedge clk);
    chk(txrdy == 1'b0, "R10", txrdy, 0);
    tx_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(txrdy == 1'b1, "R6", txrdy, 1);

    // R2 R4 R6: 8N1 x16 back to back
    set_cfg(8, 0, 0, 0, 1); cur_tag = "R2";
    pair(8'hA5, 8'h3C, "R6", 10*16);
    chk(txempty == 1'b1, "R7", txempty, 1);

    // R7: txempty falls after a write
    push_exp(8'h5A);
    @(negedge clk); wr_valid = 1'b1; wr_data = 8'h5A;
    @(negedge clk); wr_valid = 1'b0;
    @(negedge clk);
    chk(txempty == 1'b0, "R7", txempty, 0);
    drain();

    // R3: parity over active bits only
    cur_tag = "R3";
    set_cfg(5, 1, 0, 0, 1); pair(8'h13, 8'hF3, "R3", (1+5+1+1)*16);
    set_cfg(7, 1, 1, 0, 1); pair(8'h55, 8'hD5, "R3", (1+7+1+1)*16);
    set_cfg(6, 1, 0, 0, 1); pair(8'hEA, 8'h2B, "R3", (1+6+1+1)*16);

    // R4: rate factors 1 and 64
    cur_tag = "R4";
    set_cfg(8, 0, 0, 0, 0); pair(8'h96, 8'h69, "R4", 10);
    set_cfg(8, 1, 1, 0, 2); pair(8'hC3, 8'h0F, "R4", 11*64);

    // R5: stop lengths
    cur_tag = "R5";
    set_cfg(8, 0, 0, 1, 1); pair(8'h81, 8'h7E, "R5", 9*16 + 24);
    set_cfg(8, 0, 0, 2, 1); pair(8'h42, 8'h24, "R5", 9*16 + 32);
    set_cfg(8, 0, 0, 1, 0); pair(8'hF0, 8'h0F, "R5", 9 + 2);
    set_cfg(8, 0, 0, 1, 2); pair(8'h11, 8'hEE, "R5", 9*64 + 96);

    // R8: CTS drop while shifting
    cur_tag = "R8";
    set_cfg(8, 0, 0, 0, 1);
    send(8'h11);
    while (!txrdy) @(negedge clk);
    cts_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(txrdy == 1'b0, "R10", txrdy, 0);
    push_exp(8'h22);
    write_char(8'h22);
    repeat (30 * bitclks) @(negedge clk);
    chk(exp_q.size() == 1, "R8", exp_q.size(), 1);
    chk(txd == 1'b1, "R8", txd, 1);
    chk(txempty == 1'b0, "R7", txempty, 0);
    cts_n = 1'b0;
    drain();
    chk(exp_q.size() == 0, "R8", exp_q.size(), 0);

    // R9: break
    mon_on = 0;
    brk = 1'b1;
    repeat (2) @(negedge clk);
    chk(txd == 1'b0, "R9", txd, 0);
    repeat (20) @(negedge clk);
    chk(txd == 1'b0, "R9", txd, 0);
    brk = 1'b0;
    repeat (2) @(negedge clk);
    chk(txd == 1'b1, "R9", txd, 1);
    repeat (2) @(negedge clk);
    mon_on = 1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule